// File: doc/BRIEF.md
# Suspend Entry and Acknowledge Sequencer

This block decides when the processor core enters and leaves a low-power suspend state. A suspend can be requested in two ways: an external active-low request pin, or a one-cycle pulse that says a HALT has just executed. Before the core clocks may stop, the sequencer asks the core to drain. The core then finishes the current instruction, any decoded instructions still pending and their bus cycles, and it reports that it is drained. Only after that does the block raise the clock-stop request and pull the active-low acknowledge output low.

Three configuration inputs shape the behaviour. The pin-enable bit gates the request pin, which has no effect after reset until software sets it. The halt-suspend bit lets HALT on its own start a suspend. The SMM-suspend bit allows the pin to be honoured while system management mode is active. The request pin passes through a two-flop synchronizer before any logic uses it. An idle pin is pulled up, so a floating pin means no request.

There are three states. RUN is normal execution. DRAIN waits for the core to report it is drained. SUSPENDED keeps the core clocks stopped. The transitions are:
- RUN→DRAIN (pin): a qualified pin request is seen. This path has priority.
- RUN→DRAIN (halt): a HALT pulse arrives while halt-suspend is set.
- DRAIN→SUSPENDED: the core reports drained.
- SUSPENDED→RUN (pin): the synchronized pin returns high.
- SUSPENDED→RUN (halt): an interrupt event arrives.

Top module: `lp_suspend_ctrl`

## Requirements
- R1: After reset, `susp_ack_n` is 1, `clk_stop_req` is 0 and `drain_req` is 0.
- R2: While `cfg_pin_en` is 0, a low level on `susp_req_n` has no effect: the block stays in RUN and `susp_ack_n` is driven to 1 (never high impedance).
- R3: With `cfg_pin_en` at 1 and `smm_active` at 0, `drain_req` rises on the third rising clock edge after `susp_req_n` falls, because the pin first passes through two synchronizer flops.
- R4: While `smm_active` is 1, the request pin is ignored if `cfg_smm_susp_en` is 0. It is honoured, on the edge after that bit is set, if the pin is already synchronized low.
- R5: In DRAIN, `drain_req` stays at 1 and `clk_stop_req` stays at 0 for as long as `core_drained` is 0.
- R6: The clock after `core_drained` is sampled as 1 in DRAIN, the block enters SUSPENDED: `clk_stop_req` becomes 1 and `susp_ack_n` becomes 0, whichever path started the suspend.
- R7: In RUN, a `halt_pulse` with `cfg_halt_susp` at 1 moves the block to DRAIN on the next edge. With `cfg_halt_susp` at 0, the pulse has no effect.
- R8: A suspend started by the pin ends on the third rising edge after `susp_req_n` returns high. An `int_event` has no effect on it.
- R9: A suspend started by HALT ends on the edge after `int_event` is sampled as 1.
- R10: `susp_ack_n` falls in the same cycle that `clk_stop_req` rises, and rises in the same cycle that `clk_stop_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| susp_req_n | input | 1 | Asynchronous active-low suspend request pin |
| halt_pulse | input | 1 | One-cycle pulse when HALT executes |
| smm_active | input | 1 | Core is in system management mode |
| int_event | input | 1 | Interrupt signalled; wakes a HALT-caused suspend |
| cfg_pin_en | input | 1 | Enables the request pin |
| cfg_halt_susp | input | 1 | HALT alone starts a suspend |
| cfg_smm_susp_en | input | 1 | Honour the request pin during SMM |
| core_drained | input | 1 | Core has finished in-flight instructions and bus cycles |
| drain_req | output | 1 | Asks the core to drain |
| clk_stop_req | output | 1 | Asks for the core clocks to stop |
| susp_ack_n | output | 1 | Active-low suspend acknowledge |

## Verification
The assertions assume that the configuration bits change only while the block is in RUN. They also assume that `core_drained` is meaningful only while `drain_req` is high, and that `int_event` and `halt_pulse` are single-cycle pulses. The directed tasks change configuration only while the block is idle, drive every input on the falling clock edge, and raise `core_drained` only after seeing `drain_req`. Each pulse is dropped after one cycle.

// File: rtl/lp_suspend_pkg.sv
package lp_suspend_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SUSP  = 2'd2
    } susp_state_e;

    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_HALT = 1'b1
    } susp_src_e;

endpackage

// File: rtl/lp_sync_chain.sv
module lp_sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lp_req_qual.sv
module lp_req_qual (
    input  logic pin_sync_n,
    input  logic cfg_pin_en,
    input  logic smm_active,
    input  logic cfg_smm_susp_en,
    output logic pin_req,
    output logic pin_released
);
    logic smm_ok;

    always_comb begin
        smm_ok       = !smm_active || cfg_smm_susp_en;
        pin_req      = !pin_sync_n && cfg_pin_en && smm_ok;
        pin_released = pin_sync_n;
    end
endmodule

// File: rtl/lp_susp_fsm.sv
module lp_susp_fsm
    import lp_suspend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_req,
    input  logic pin_released,
    input  logic halt_pulse,
    input  logic cfg_halt_susp,
    input  logic int_event,
    input  logic core_drained,
    output logic drain_req,
    output logic clk_stop_req,
    output logic susp_ack_n
);
    susp_state_e state_q, state_d;
    susp_src_e   src_q, src_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            src_q   <= SRC_PIN;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_RUN: begin
                if (pin_req) begin
                    state_d = ST_DRAIN;
                    src_d   = SRC_PIN;
                end else if (halt_pulse && cfg_halt_susp) begin
                    state_d = ST_DRAIN;
                    src_d   = SRC_HALT;
                end
            end
            ST_DRAIN: begin
                if (core_drained) state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (src_q == SRC_PIN) begin
                    if (pin_released) state_d = ST_RUN;
                end else begin
                    if (int_event) state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        drain_req    = 1'b0;
        clk_stop_req = 1'b0;
        susp_ack_n   = 1'b1;
        unique case (state_q)
            ST_RUN:   ;
            ST_DRAIN: drain_req = 1'b1;
            ST_SUSP: begin
                clk_stop_req = 1'b1;
                susp_ack_n   = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lp_suspend_ctrl.sv
module lp_suspend_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_req_n,
    input  logic halt_pulse,
    input  logic smm_active,
    input  logic int_event,
    input  logic cfg_pin_en,
    input  logic cfg_halt_susp,
    input  logic cfg_smm_susp_en,
    input  logic core_drained,
    output logic drain_req,
    output logic clk_stop_req,
    output logic susp_ack_n
);
    logic pin_sync_n;
    logic pin_req;
    logic pin_released;

    lp_sync_chain #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (susp_req_n),
        .q     (pin_sync_n)
    );

    lp_req_qual u_qual (
        .pin_sync_n      (pin_sync_n),
        .cfg_pin_en      (cfg_pin_en),
        .smm_active      (smm_active),
        .cfg_smm_susp_en (cfg_smm_susp_en),
        .pin_req         (pin_req),
        .pin_released    (pin_released)
    );

    lp_susp_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_req       (pin_req),
        .pin_released  (pin_released),
        .halt_pulse    (halt_pulse),
        .cfg_halt_susp (cfg_halt_susp),
        .int_event     (int_event),
        .core_drained  (core_drained),
        .drain_req     (drain_req),
        .clk_stop_req  (clk_stop_req),
        .susp_ack_n    (susp_ack_n)
    );
endmodule

// File: rtl/lp_suspend_ctrl_chk.sv
module lp_suspend_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_pulse,
    input logic cfg_pin_en,
    input logic cfg_halt_susp,
    input logic core_drained,
    input logic drain_req,
    input logic clk_stop_req,
    input logic susp_ack_n
);
    logic in_run;
    assign in_run = !drain_req && !clk_stop_req;

    AST_DRAIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain_req && clk_stop_req)) else $error("drain and stop together"); // R5

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !core_drained) |=> (drain_req && !clk_stop_req)) else $error("drain left early"); // R5

    AST_ENTRY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_ack_n) |-> ($past(drain_req) && $past(core_drained))) else $error("ack without drain"); // R6

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && halt_pulse && cfg_halt_susp) |=> drain_req) else $error("halt not taken"); // R7

    AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !cfg_pin_en && !(halt_pulse && cfg_halt_susp)) |=> in_run) else $error("left run without cause"); // R2

    AST_ACK_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop_req) |-> $fell(susp_ack_n)) else $error("ack not with stop rise"); // R10

    AST_ACK_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_stop_req) |-> $rose(susp_ack_n)) else $error("ack not with stop fall"); // R10
endmodule

bind lp_suspend_ctrl lp_suspend_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_pulse    (halt_pulse),
    .cfg_pin_en    (cfg_pin_en),
    .cfg_halt_susp (cfg_halt_susp),
    .core_drained  (core_drained),
    .drain_req     (drain_req),
    .clk_stop_req  (clk_stop_req),
    .susp_ack_n    (susp_ack_n)
);

// File: tb/lp_suspend_ctrl_tb.sv
`timescale 1ns/100ps
module lp_suspend_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic susp_req_n = 1'b1;
    logic halt_pulse = 1'b0;
    logic smm_active = 1'b0;
    logic int_event = 1'b0;
    logic cfg_pin_en = 1'b0;
    logic cfg_halt_susp = 1'b0;
    logic cfg_smm_susp_en = 1'b0;
    logic core_drained = 1'b0;
    logic drain_req, clk_stop_req, susp_ack_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lp_suspend_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .susp_req_n(susp_req_n), .halt_pulse(halt_pulse),
        .smm_active(smm_active), .int_event(int_event), .cfg_pin_en(cfg_pin_en),
        .cfg_halt_susp(cfg_halt_susp), .cfg_smm_susp_en(cfg_smm_susp_en),
        .core_drained(core_drained), .drain_req(drain_req),
        .clk_stop_req(clk_stop_req), .susp_ack_n(susp_ack_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // state triple: drain, stop, ack_n
    task automatic chk_state(input string tag, input logic d, input logic s, input logic a);
        chk(tag, "drain_req", drain_req, d);
        chk(tag, "clk_stop_req", clk_stop_req, s);
        chk(tag, "susp_ack_n", susp_ack_n, a);
    endtask

    task automatic t_reset;
        tick(1);
        chk_state("R1", 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        tick(2);
        chk_state("R1", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_pin_disabled;
        cfg_pin_en = 1'b0;
        susp_req_n = 1'b0;
        tick(6);
        chk_state("R2", 1'b0, 1'b0, 1'b1);
        susp_req_n = 1'b1;
        tick(4);
    endtask

    task automatic t_pin_cycle;
        cfg_pin_en = 1'b1;
        susp_req_n = 1'b0;
        tick(2);
        chk("R3", "drain before sync", drain_req, 1'b0);
        tick(1);
        chk("R3", "drain after sync", drain_req, 1'b1);
        tick(4);
        chk_state("R5", 1'b1, 1'b0, 1'b1);
        core_drained = 1'b1;
        tick(1);
        chk_state("R6", 1'b0, 1'b1, 1'b0);
        core_drained = 1'b0;
        int_event = 1'b1;
        tick(1);
        int_event = 1'b0;
        tick(1);
        chk("R8", "int ignored", clk_stop_req, 1'b1);
        susp_req_n = 1'b1;
        tick(2);
        chk_state("R8", 1'b0, 1'b1, 1'b0);
        tick(1);
        chk_state("R10", 1'b0, 1'b0, 1'b1);
        tick(2);
    endtask

    task automatic t_smm;
        cfg_pin_en = 1'b1;
        smm_active = 1'b1;
        cfg_smm_susp_en = 1'b0;
        susp_req_n = 1'b0;
        tick(6);
        chk_state("R4", 1'b0, 1'b0, 1'b1);
        cfg_smm_susp_en = 1'b1;
        tick(1);
        chk("R4", "drain with smm enable", drain_req, 1'b1);
        core_drained = 1'b1;
        tick(1);
        chk_state("R6", 1'b0, 1'b1, 1'b0);
        core_drained = 1'b0;
        susp_req_n = 1'b1;
        tick(3);
        chk_state("R8", 1'b0, 1'b0, 1'b1);
        smm_active = 1'b0;
        cfg_smm_susp_en = 1'b0;
        tick(2);
    endtask

    task automatic t_halt_disabled;
        cfg_halt_susp = 1'b0;
        halt_pulse = 1'b1;
        tick(1);
        halt_pulse = 1'b0;
        chk_state("R7", 1'b0, 1'b0, 1'b1);
        tick(3);
        chk_state("R7", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_halt_cycle;
        cfg_halt_susp = 1'b1;
        halt_pulse = 1'b1;
        tick(1);
        halt_pulse = 1'b0;
        chk("R7", "halt drain", drain_req, 1'b1);
        tick(3);
        chk_state("R5", 1'b1, 1'b0, 1'b1);
        core_drained = 1'b1;
        tick(1);
        chk_state("R6", 1'b0, 1'b1, 1'b0);
        core_drained = 1'b0;
        tick(5);
        chk("R9", "stays suspended", clk_stop_req, 1'b1);
        int_event = 1'b1;
        tick(1);
        int_event = 1'b0;
        chk_state("R9", 1'b0, 1'b0, 1'b1);
        chk("R10", "ack with stop", susp_ack_n, ~clk_stop_req);
        cfg_halt_susp = 1'b0;
        tick(2);
    endtask

    initial begin
        t_reset();
        t_pin_disabled();
        t_pin_cycle();
        t_smm();
        t_halt_disabled();
        t_halt_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule